// File: doc/BRIEF.md
# Trace Frame Word Unpacker

This block sits behind a trace capture memory and turns each 32-bit stored word back into the per-cycle trace records it was packed from. Every record carries a 3-bit pipeline status, a 16-bit packet field, a trace-sync flag and a trigger flag. The trace port width that was in use during capture decides how many records share one word. A narrow 4-bit port packs three records per word, an 8-bit port packs two, and a 16-bit port packs one.

Words arrive on a valid/ready interface. Records leave on a second valid/ready interface, one record per cycle at most. A word is stored in a single register and its records are emitted in order of rising bit position. The next word may be taken in the same cycle that the last record of the current word leaves, so a steady stream keeps the output busy on every cycle. One pipeline-status value is reserved to mark a trigger cycle. When a record's extracted status equals that value, the block reports the low three packet bits as the status and raises the trigger flag. The mode input must stay constant while a word is being unpacked.

Top module: `trace_unpack`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `recValid` is 0 and `wordReady` is 1.
- R2: Mode 2'b00 (4-bit port) yields three records per word. Record 0 has status = bits 2:0, packet = bits 6:3 and sync = bit 7. Record 1 has status = {2'b00, bit 8}, packet = bits 14:11 and sync = bit 15. Record 2 has status = {2'b00, bit 16}, packet = bits 22:19 and sync = bit 23.
- R3: Mode 2'b01 (8-bit port) yields two records per word. Record 0 has status = bits 2:0, packet = bits 10:3 and sync = bit 11. Record 1 has status = bits 14:12, packet = bits 22:15 and sync = bit 23.
- R4: Modes 2'b10 and 2'b11 (16-bit port) yield one record per word, with status = bits 2:0, packet = bits 18:3 and sync = bit 19.
- R5: When the extracted status equals the parameter `TR_CODE` (default 3'b110), the record shows packet bits 2:0 as its status and `recTrig` = 1. Otherwise `recTrig` = 0 and the status is passed through unchanged.
- R6: Records leave in order of rising bit position within a word, and words are unpacked in the order they were accepted.
- R7: `wordReady` is 0 while a record is pending and is not the last record of its word being taken. `wordReady` is 1 in the cycle the last record is taken, and a word accepted at a clock edge presents its first record right after that edge.
- R8: While `recValid` = 1 and `recReady` = 0, every record output holds its value into the next cycle.
- R9: The packet is zero-extended to 16 bits. Bits 15:4 are 0 in mode 2'b00, and bits 15:8 are 0 in mode 2'b01.
- R10: A word offered while `wordReady` = 0 is not taken. It is taken later, and its records follow those of the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Port width: 00 = 4-bit, 01 = 8-bit, 10 and 11 = 16-bit |
| wordValid | input | 1 | Captured word offered |
| wordReady | output | 1 | Word taken when high together with `wordValid` |
| wordData | input | 32 | Captured trace word |
| recValid | output | 1 | Record present |
| recReady | input | 1 | Record taken when high together with `recValid` |
| recStatus | output | 3 | Pipeline status, after trigger substitution |
| recPacket | output | 16 | Packet field, zero-extended |
| recSync | output | 1 | Trace-sync flag |
| recTrig | output | 1 | Trigger flag |

## Verification
A word accepted at a rising edge shows its first record combinationally right after that edge, and each later record follows one edge after the previous record is taken. `wordReady` is combinational in the same cycle as `recReady`. The bench therefore sets its inputs at the falling edge, waits a short settle delay, and then judges both handshakes and compares the record against the head of its expected queue before the next rising edge. Every mode is swept twice, once with the output always ready and once with random stalls on both sides. Statuses 0 to 7 are forced in the first words, and trigger codes are planted in every status field that can hold one.

// File: rtl/trace_unpack_pkg.sv
package trace_unpack_pkg;

  // Fixed geometry of a captured word and of one record
  localparam int WORD_W   = 32;
  localparam int PKT_W    = 16;
  localparam int ST_W     = 3;
  localparam int SLOT_W   = 2;

  // Bit stride between consecutive records inside a word
  localparam int NIB_STRIDE  = 8;
  localparam int BYTE_STRIDE = 12;

  typedef enum logic [1:0] {
    PORT_4  = 2'b00,
    PORT_8  = 2'b01,
    PORT_16 = 2'b10,
    PORT_16X = 2'b11
  } portMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [SLOT_W-1:0] slot;
  } dpCtrl_t;

  // Index of the final record of a word in the given mode
  function automatic logic [SLOT_W-1:0] lastSlot(input logic [1:0] m);
    case (m)
      PORT_4:  lastSlot = SLOT_W'(2);
      PORT_8:  lastSlot = SLOT_W'(1);
      default: lastSlot = SLOT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/trace_unpack_ctrl.sv
module trace_unpack_ctrl
  import trace_unpack_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic [1:0] mode,
  input  logic    wordValid,
  output logic    wordReady,
  output logic    recValid,
  input  logic    recReady,
  output dpCtrl_t dpCtrl
);

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic              take;
  logic              finish;
  logic              accept;

  always_comb begin
    take      = busy && recReady;
    finish    = take && (slot == lastSlot(mode));
    wordReady = !busy || finish;
    accept    = wordValid && wordReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (finish) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (take) begin
      slot <= slot + 1'b1;
    end
  end

  assign recValid    = busy;
  assign dpCtrl.load = accept;
  assign dpCtrl.slot = slot;

endmodule

// File: rtl/trace_unpack_dp.sv
module trace_unpack_dp
  import trace_unpack_pkg::*;
#(
  parameter logic [ST_W-1:0] TR_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] wordData,
  input  dpCtrl_t           dpCtrl,
  output logic [ST_W-1:0]   recStatus,
  output logic [PKT_W-1:0]  recPacket,
  output logic              recSync,
  output logic              recTrig
);

  logic [WORD_W-1:0] wordQ;
  logic [WORD_W-1:0] nibView;
  logic [WORD_W-1:0] byteView;
  logic [ST_W-1:0]   rawStatus;
  logic [PKT_W-1:0]  pkt;
  logic              sync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordQ <= '0;
    else if (dpCtrl.load) wordQ <= wordData;
  end

  // Align the selected record to bit 0 for each packing density
  always_comb begin
    nibView  = wordQ >> (NIB_STRIDE  * int'(dpCtrl.slot));
    byteView = wordQ >> (BYTE_STRIDE * int'(dpCtrl.slot));
  end

  always_comb begin
    case (mode)
      PORT_4: begin
        rawStatus = (dpCtrl.slot == '0) ? nibView[2:0] : {2'b00, nibView[0]};
        pkt       = {{(PKT_W-4){1'b0}}, nibView[6:3]};
        sync      = nibView[7];
      end
      PORT_8: begin
        rawStatus = byteView[2:0];
        pkt       = {{(PKT_W-8){1'b0}}, byteView[10:3]};
        sync      = byteView[11];
      end
      default: begin
        rawStatus = wordQ[2:0];
        pkt       = wordQ[18:3];
        sync      = wordQ[19];
      end
    endcase
  end

  // Trigger cycles carry their real status in the low packet bits
  always_comb begin
    recTrig   = (rawStatus == TR_CODE);
    recStatus = recTrig ? pkt[ST_W-1:0] : rawStatus;
    recPacket = pkt;
    recSync   = sync;
  end

endmodule

// File: rtl/trace_unpack.sv
module trace_unpack
  import trace_unpack_pkg::*;
#(
  parameter logic [2:0] TR_CODE = 3'b110
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  logic        wordValid,
  output logic        wordReady,
  input  logic [31:0] wordData,
  output logic        recValid,
  input  logic        recReady,
  output logic [2:0]  recStatus,
  output logic [15:0] recPacket,
  output logic        recSync,
  output logic        recTrig
);

  dpCtrl_t dpCtrl;

  trace_unpack_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .recValid  (recValid),
    .recReady  (recReady),
    .dpCtrl    (dpCtrl)
  );

  trace_unpack_dp #(.TR_CODE(TR_CODE)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .wordData  (wordData),
    .dpCtrl    (dpCtrl),
    .recStatus (recStatus),
    .recPacket (recPacket),
    .recSync   (recSync),
    .recTrig   (recTrig)
  );

endmodule

// File: rtl/trace_unpack_chk.sv
module trace_unpack_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  mode,
  input logic        wordValid,
  input logic        wordReady,
  input logic [31:0] wordData,
  input logic        recValid,
  input logic        recReady,
  input logic [2:0]  recStatus,
  input logic [15:0] recPacket,
  input logic        recSync,
  input logic        recTrig
);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid && $stable(recStatus) && $stable(recPacket)
                              && $stable(recSync) && $stable(recTrig));

  // R7
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |-> !wordReady);

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && wordReady |=> recValid);

  // R4
  single_chk: assert property (@(posedge clk) disable iff (!rstN)
    mode[1] && recValid && recReady |-> wordReady);

  // R9
  zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid && mode == 2'b00 |-> recPacket[15:4] == 12'h000);

  // R5
  trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recTrig |-> recStatus == recPacket[2:0]);

endmodule

bind trace_unpack trace_unpack_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .mode      (mode),
  .wordValid (wordValid),
  .wordReady (wordReady),
  .wordData  (wordData),
  .recValid  (recValid),
  .recReady  (recReady),
  .recStatus (recStatus),
  .recPacket (recPacket),
  .recSync   (recSync),
  .recTrig   (recTrig)
);

// File: tb/trace_unpack_tb_top.sv
module trace_unpack_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  mode;
  logic        wordValid;
  logic        wordReady;
  logic [31:0] wordData;
  logic        recValid;
  logic        recReady;
  logic [2:0]  recStatus;
  logic [15:0] recPacket;
  logic        recSync;
  logic        recTrig;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  trace_unpack dut_i (
    .clk(clk), .rstN(rstN), .mode(mode),
    .wordValid(wordValid), .wordReady(wordReady), .wordData(wordData),
    .recValid(recValid), .recReady(recReady), .recStatus(recStatus),
    .recPacket(recPacket), .recSync(recSync), .recTrig(recTrig)
  );

  // Expected record queue
  logic [2:0]  expSt [1024];
  logic [15:0] expPk [1024];
  logic        expSy [1024];
  logic        expTg [1024];
  logic        expLast [1024];
  int head = 0;
  int tail = 0;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [31:0] makeWord(input int i, input int m);
    logic [31:0] w;
    w = (32'(i) * 32'h9E37_79B9) ^ (32'(m) << 27) ^ 32'h5A3C_0F96;
    if (i < 8)           w[2:0] = 3'(i);
    else if (i % 4 == 0) w[2:0] = 3'b110;
    if (m == 1 && i % 3 == 1) w[14:12] = 3'b110;
    return w;
  endfunction

  task automatic pushWord(input logic [31:0] w, input int m);
    int n;
    n = (m == 0) ? 3 : (m == 1) ? 2 : 1;
    for (int s = 0; s < n; s++) begin
      logic [31:0] st, pk, sy;
      if (m == 0) begin
        st = (s == 0) ? (w & 32'h7) : ((w >> (8*s)) & 32'h1);
        pk = (w >> (3 + 8*s)) & 32'hF;
        sy = (w >> (7 + 8*s)) & 32'h1;
      end else if (m == 1) begin
        st = (w >> (12*s)) & 32'h7;
        pk = (w >> (3 + 12*s)) & 32'hFF;
        sy = (w >> (11 + 12*s)) & 32'h1;
      end else begin
        st = w & 32'h7;
        pk = (w >> 3) & 32'hFFFF;
        sy = (w >> 19) & 32'h1;
      end
      expTg[tail % 1024] = (st == 32'd6);
      expSt[tail % 1024] = (st == 32'd6) ? 3'(pk & 32'h7) : 3'(st);
      expPk[tail % 1024] = 16'(pk);
      expSy[tail % 1024] = sy[0];
      expLast[tail % 1024] = (s == n - 1);
      tail++;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic runPhase(input int m, input int pass, input int nWords);
    int sent = 0;
    bit prevStall = 0;
    logic [2:0] hSt; logic [15:0] hPk; logic hSy, hTg;
    string tag;
    tag = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
    while (sent < nWords || head != tail) begin
      @(negedge clk);
      mode = 2'(m);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      wordValid = (sent < nWords) && (pass == 0 || lcg[16]);
      wordData  = makeWord(sent + 100*pass, m);
      recReady  = (pass == 0) ? 1'b1 : lcg[19];
      #1;
      if (prevStall && recValid) begin
        check(recStatus == hSt && recPacket == hPk && recSync == hSy && recTrig == hTg,
              "R8", "held record", {recStatus, recPacket, recSync, recTrig},
              {hSt, hPk, hSy, hTg});
      end
      prevStall = 0;
      if (head != tail) begin
        check(recValid, "R6/R7", "record pending", 32'(recValid), 32'd1);
      end else begin
        check(!recValid, "R6", "no record pending", 32'(recValid), 32'd0);
      end
      if (recValid && head != tail) begin
        int h;
        h = head % 1024;
        if (m < 2) begin
          // R9 zero extension above the packet field
          check((m == 0) ? (recPacket[15:4] == 0) : (recPacket[15:8] == 0),
                "R9", "packet upper bits", 32'(recPacket), 32'(expPk[h]));
        end
        if (recReady) begin
          check(recStatus == expSt[h] && recPacket == expPk[h] &&
                recSync == expSy[h] && recTrig == expTg[h],
                expTg[h] ? "R5/R6/R10" : {tag, "/R6/R10"}, "record fields",
                {recStatus, recPacket, recSync, recTrig},
                {expSt[h], expPk[h], expSy[h], expTg[h]});
          check(wordReady == expLast[h], "R7", "ready on take",
                32'(wordReady), 32'(expLast[h]));
          head++;
        end else begin
          check(!wordReady, "R7", "ready during stall", 32'(wordReady), 32'd0);
          prevStall = 1;
          hSt = recStatus; hPk = recPacket; hSy = recSync; hTg = recTrig;
        end
      end
      if (wordValid && wordReady) begin
        pushWord(wordData, m);
        sent++;
      end
    end
    @(negedge clk);
    wordValid = 1'b0;
    recReady  = 1'b0;
    #1;
    check(!recValid && wordReady, "R6", "idle after drain",
          {30'd0, recValid, wordReady}, 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R6 watchdog expired: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; mode = 2'b00; wordValid = 1'b0; wordData = '0; recReady = 1'b0;
    repeat (3) @(negedge clk);
    check(!recValid && wordReady, "R1", "in reset", {30'd0, recValid, wordReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(!recValid && wordReady, "R1", "after reset", {30'd0, recValid, wordReady}, 32'd1);
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) runPhase(m, p, 40);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule